// File: doc/BRIEF.md
# Relocatable Page Address Generator

This unit forms memory addresses for an 8-bit accumulator processor with a 16-bit address bus. It does not assume a fixed page for the zero page, the stack page or the vector table. The high byte of every zero-page style address comes from a direct-page register. The high byte of every stack address comes from a stack-page register. Vector fetches are offset from a 16-bit vector base register. All three registers return to their compatible values on a hardware reset and on a software-reset request.

Indirect zero-page accesses can adjust their pointer automatically by the unsigned value of the secondary accumulator B. In post-increment form, the access uses the fetched pointer as it is, and the unit offers the pointer plus B for write-back. In pre-decrement form, the pointer minus B is both the effective address and the write-back value. The unit is combinational from its operands to its address outputs, apart from the page registers. The surrounding sequencer decides when each output is placed on the bus.

Top module: `page_addr_gen`

## Requirements
- R1: After reset, the direct page is 0x00, the stack page is 0x01 and the vector base is 0xFFFA.
- R2: With mode 0 (direct), `ea` = {direct page, `operand`}.
- R3: With mode 1 (indexed), `ea` = {direct page, (`operand` + `idx_in`) mod 256`}`. The carry out of the low byte never reaches the high byte.
- R4: With mode 7 (pointer high byte), `ea` = {direct page, (`operand` + 1) mod 256}. Mode 0 with the same operand addresses the pointer low byte.
- R5: Mode 2 (push) gives `ea` = {stack page, `sp_in`} and `sp_next` = (`sp_in` − 1) mod 256. Mode 3 (pull) gives `ea` = {stack page, (`sp_in` + 1) mod 256} and `sp_next` equal to that same low byte. In every other mode, `sp_next` = `sp_in`.
- R6: With mode 4 (post-increment), `ea` = `ptr_in`, `ptr_wb` = (`ptr_in` + B) mod 65536, and `ptr_wb_en` = 1. B is zero-extended.
- R7: With mode 5 (pre-decrement), `ea` = `ptr_wb` = (`ptr_in` − B) mod 65536, and `ptr_wb_en` = 1.
- R8: With mode 6 (plain indirect), `ea` = `ptr_in` and `ptr_wb_en` = 0. `ptr_wb_en` is also 0 in modes 0, 1, 2, 3 and 7.
- R9: `vec_addr` = (vector base + offset + `vec_byte`) mod 65536. The offset is 0 for `vec_sel` 0 (NMI), 2 for 1 (reset), and 4 for 2 (IRQ) and for 3 (BRK).
- R10: On a clock edge, `dp_wr` loads the direct page from `x_in`, `spg_wr` loads the stack page from `x_in`, and `vp_wr` loads the vector base from `vp_wdata`.
- R11: `x_out` shows the direct page when `xfer_sel` = 0 and the stack page when it is 1. `flag_n` = bit 7 of `x_out`, and `flag_z` = 1 exactly when `x_out` is 0.
- R12: `soft_rst` on a clock edge reloads the three registers with their reset values. It takes priority over any load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| soft_rst | input | 1 | Software-reset request |
| dp_wr | input | 1 | Load the direct page from x_in |
| spg_wr | input | 1 | Load the stack page from x_in |
| vp_wr | input | 1 | Load the vector base from vp_wdata |
| x_in | input | 8 | X register value |
| vp_wdata | input | 16 | New vector base |
| mode | input | 3 | Address mode select (0 to 7, see requirements) |
| operand | input | 8 | Zero-page operand byte |
| idx_in | input | 8 | Index register value |
| sp_in | input | 8 | Current stack pointer |
| b_in | input | 8 | Secondary accumulator B |
| ptr_in | input | 16 | Fetched indirect pointer |
| vec_sel | input | 2 | Vector select: 0 NMI, 1 reset, 2 IRQ, 3 BRK |
| vec_byte | input | 1 | 0 for the vector low byte, 1 for the high byte |
| xfer_sel | input | 1 | Page register copied to X: 0 direct, 1 stack |
| ea | output | 16 | Effective address |
| ptr_wb | output | 16 | Adjusted pointer for write-back |
| ptr_wb_en | output | 1 | Write-back is required |
| sp_next | output | 8 | Stack pointer after the access |
| vec_addr | output | 16 | Vector fetch address |
| x_out | output | 8 | Selected page register for transfer to X |
| flag_n | output | 1 | Negative flag of x_out |
| flag_z | output | 1 | Zero flag of x_out |

## Verification
A corrupted page register shows up at once in the high byte of `ea` for every zero-page or stack mode. A corrupted vector base shows up in `vec_addr` in the same cycle. None of these faults waits for a bus access. An error in the adder or wrap logic appears only for particular operand values, such as an index that crosses 0xFF or a pointer minus B that falls below zero. For that reason the bench sweeps every operand, stack pointer and B value against a few page and pointer values.

// File: rtl/pag_pkg.sv
package pag_pkg;
  typedef enum logic [2:0] {
    AM_ZP   = 3'd0,
    AM_ZPX  = 3'd1,
    AM_PUSH = 3'd2,
    AM_PULL = 3'd3,
    AM_POST = 3'd4,
    AM_PRE  = 3'd5,
    AM_IND  = 3'd6,
    AM_ZPHI = 3'd7
  } amode_t;

  typedef enum logic [1:0] {
    VS_NMI = 2'd0,
    VS_RST = 2'd1,
    VS_IRQ = 2'd2,
    VS_BRK = 2'd3
  } vsel_t;
endpackage

// File: rtl/pag_rst_sync.sv
module pag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/pag_page_regs.sv
module pag_page_regs #(
  parameter int PW = 8,
  parameter logic [PW-1:0]   DP_INIT  = '0,
  parameter logic [PW-1:0]   SPG_INIT = PW'(1),
  parameter logic [2*PW-1:0] VP_INIT  = {{PW{1'b1}}, {(PW-3){1'b1}}, 3'b010}
) (
  input  logic            clk,
  input  logic            rst_s_n,
  input  logic            soft_rst,
  input  logic            dp_wr,
  input  logic            spg_wr,
  input  logic            vp_wr,
  input  logic [PW-1:0]   x_in,
  input  logic [2*PW-1:0] vp_wdata,
  output logic [PW-1:0]   dp_q,
  output logic [PW-1:0]   spg_q,
  output logic [2*PW-1:0] vp_q
);
  logic [PW-1:0]   dp_d, spg_d;
  logic [2*PW-1:0] vp_d;
  logic            dp_en, spg_en, vp_en;

  always_comb begin
    dp_en  = soft_rst | dp_wr;
    spg_en = soft_rst | spg_wr;
    vp_en  = soft_rst | vp_wr;
    dp_d   = soft_rst ? DP_INIT  : x_in;
    spg_d  = soft_rst ? SPG_INIT : x_in;
    vp_d   = soft_rst ? VP_INIT  : vp_wdata;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      dp_q  <= DP_INIT;
      spg_q <= SPG_INIT;
      vp_q  <= VP_INIT;
    end else begin
      if (dp_en)  dp_q  <= dp_d;
      if (spg_en) spg_q <= spg_d;
      if (vp_en)  vp_q  <= vp_d;
    end
  end
endmodule

// File: rtl/pag_addr_calc.sv
module pag_addr_calc
  import pag_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic [2:0]      mode,
  input  logic [PW-1:0]   operand,
  input  logic [PW-1:0]   idx_in,
  input  logic [PW-1:0]   sp_in,
  input  logic [PW-1:0]   b_in,
  input  logic [2*PW-1:0] ptr_in,
  input  logic [PW-1:0]   dp_q,
  input  logic [PW-1:0]   spg_q,
  output logic [2*PW-1:0] ea,
  output logic [2*PW-1:0] ptr_wb,
  output logic            ptr_wb_en,
  output logic [PW-1:0]   sp_next
);
  localparam int AW = 2 * PW;
  localparam logic [PW-1:0] ONE_B = PW'(1);

  amode_t          am;
  logic [PW-1:0]   zpx_lo, zhi_lo, pull_lo, push_lo;
  logic [AW-1:0]   b_ext, ptr_post, ptr_pre;

  always_comb begin
    am       = amode_t'(mode);
    zpx_lo   = operand + idx_in;
    zhi_lo   = operand + ONE_B;
    pull_lo  = sp_in + ONE_B;
    push_lo  = sp_in - ONE_B;
    b_ext    = {{PW{1'b0}}, b_in};
    ptr_post = ptr_in + b_ext;
    ptr_pre  = ptr_in - b_ext;

    ea        = {dp_q, operand};
    ptr_wb    = ptr_in;
    ptr_wb_en = 1'b0;
    sp_next   = sp_in;
    case (am)
      AM_ZP:   ea = {dp_q, operand};
      AM_ZPX:  ea = {dp_q, zpx_lo};
      AM_ZPHI: ea = {dp_q, zhi_lo};
      AM_PUSH: begin
        ea      = {spg_q, sp_in};
        sp_next = push_lo;
      end
      AM_PULL: begin
        ea      = {spg_q, pull_lo};
        sp_next = pull_lo;
      end
      AM_POST: begin
        ea        = ptr_in;
        ptr_wb    = ptr_post;
        ptr_wb_en = 1'b1;
      end
      AM_PRE: begin
        ea        = ptr_pre;
        ptr_wb    = ptr_pre;
        ptr_wb_en = 1'b1;
      end
      AM_IND:  ea = ptr_in;
      default: ea = {dp_q, operand};
    endcase
  end
endmodule

// File: rtl/pag_vec_calc.sv
module pag_vec_calc
  import pag_pkg::*;
#(
  parameter int PW = 8,
  parameter int NMI_OFF = 0,
  parameter int RST_OFF = 2,
  parameter int IRQ_OFF = 4
) (
  input  logic [2*PW-1:0] vp_q,
  input  logic [1:0]      vec_sel,
  input  logic            vec_byte,
  output logic [2*PW-1:0] vec_addr
);
  localparam int AW = 2 * PW;

  logic [AW-1:0] off;

  always_comb begin
    case (vsel_t'(vec_sel))
      VS_NMI:  off = AW'(NMI_OFF);
      VS_RST:  off = AW'(RST_OFF);
      default: off = AW'(IRQ_OFF);
    endcase
    vec_addr = vp_q + off + {{(AW-1){1'b0}}, vec_byte};
  end
endmodule

// File: rtl/page_addr_gen.sv
module page_addr_gen #(
  parameter int PW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            dp_wr,
  input  logic            spg_wr,
  input  logic            vp_wr,
  input  logic [PW-1:0]   x_in,
  input  logic [2*PW-1:0] vp_wdata,
  input  logic [2:0]      mode,
  input  logic [PW-1:0]   operand,
  input  logic [PW-1:0]   idx_in,
  input  logic [PW-1:0]   sp_in,
  input  logic [PW-1:0]   b_in,
  input  logic [2*PW-1:0] ptr_in,
  input  logic [1:0]      vec_sel,
  input  logic            vec_byte,
  input  logic            xfer_sel,
  output logic [2*PW-1:0] ea,
  output logic [2*PW-1:0] ptr_wb,
  output logic            ptr_wb_en,
  output logic [PW-1:0]   sp_next,
  output logic [2*PW-1:0] vec_addr,
  output logic [PW-1:0]   x_out,
  output logic            flag_n,
  output logic            flag_z
);
  logic            rst_s_n;
  logic [PW-1:0]   dp_q, spg_q;
  logic [2*PW-1:0] vp_q;

  pag_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  pag_page_regs #(.PW(PW)) u_regs (
    .clk(clk), .rst_s_n(rst_s_n), .soft_rst(soft_rst),
    .dp_wr(dp_wr), .spg_wr(spg_wr), .vp_wr(vp_wr),
    .x_in(x_in), .vp_wdata(vp_wdata),
    .dp_q(dp_q), .spg_q(spg_q), .vp_q(vp_q)
  );

  pag_addr_calc #(.PW(PW)) u_addr (
    .mode(mode), .operand(operand), .idx_in(idx_in), .sp_in(sp_in),
    .b_in(b_in), .ptr_in(ptr_in), .dp_q(dp_q), .spg_q(spg_q),
    .ea(ea), .ptr_wb(ptr_wb), .ptr_wb_en(ptr_wb_en), .sp_next(sp_next)
  );

  pag_vec_calc #(.PW(PW)) u_vec (
    .vp_q(vp_q), .vec_sel(vec_sel), .vec_byte(vec_byte), .vec_addr(vec_addr)
  );

  always_comb begin
    x_out  = xfer_sel ? spg_q : dp_q;
    flag_n = x_out[PW-1];
    flag_z = (x_out == '0);
  end
endmodule

// File: rtl/pag_checker.sv
module pag_checker #(
  parameter int PW = 8
) (
  input logic            clk,
  input logic            rst_s_n,
  input logic            soft_rst,
  input logic            dp_wr,
  input logic [PW-1:0]   x_in,
  input logic [2:0]      mode,
  input logic [PW-1:0]   b_in,
  input logic [2*PW-1:0] ptr_in,
  input logic [2*PW-1:0] ea,
  input logic [2*PW-1:0] ptr_wb,
  input logic            ptr_wb_en,
  input logic [PW-1:0]   dp_q,
  input logic [PW-1:0]   spg_q,
  input logic [2*PW-1:0] vp_q
);
  localparam logic [2*PW-1:0] VP_RST = {{PW{1'b1}}, {(PW-3){1'b1}}, 3'b010};

  a_r2_zp_page: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode == 3'd0 || mode == 3'd1 || mode == 3'd7) |-> ea[2*PW-1:PW] == dp_q);

  a_r5_stack_page: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode == 3'd2 || mode == 3'd3) |-> ea[2*PW-1:PW] == spg_q);

  a_r6_post_inc: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode == 3'd4) |-> (ea == ptr_in && ptr_wb_en &&
                         ptr_wb - ptr_in == {{PW{1'b0}}, b_in}));

  a_r7_pre_dec: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode == 3'd5) |-> (ea == ptr_wb && ptr_wb_en &&
                         ptr_in - ptr_wb == {{PW{1'b0}}, b_in}));

  a_r8_no_wb: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode != 3'd4 && mode != 3'd5) |-> !ptr_wb_en);

  a_r10_dp_load: assert property (@(posedge clk) disable iff (!rst_s_n)
    (dp_wr && !soft_rst) |=> dp_q == $past(x_in));

  a_r12_soft_reset: assert property (@(posedge clk) disable iff (!rst_s_n)
    soft_rst |=> (dp_q == '0 && spg_q == PW'(1) && vp_q == VP_RST));
endmodule

bind page_addr_gen pag_checker #(.PW(PW)) u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .soft_rst(soft_rst), .dp_wr(dp_wr),
  .x_in(x_in), .mode(mode), .b_in(b_in), .ptr_in(ptr_in), .ea(ea),
  .ptr_wb(ptr_wb), .ptr_wb_en(ptr_wb_en), .dp_q(dp_q), .spg_q(spg_q),
  .vp_q(vp_q)
);

// File: tb/page_addr_gen_tb_top.sv
module page_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, soft_rst, dp_wr, spg_wr, vp_wr, vec_byte, xfer_sel;
  logic [7:0]  x_in, operand, idx_in, sp_in, b_in;
  logic [15:0] vp_wdata, ptr_in;
  logic [2:0]  mode;
  logic [1:0]  vec_sel;
  logic [15:0] ea, ptr_wb, vec_addr;
  logic        ptr_wb_en, flag_n, flag_z;
  logic [7:0]  sp_next, x_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  page_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .dp_wr(dp_wr),
    .spg_wr(spg_wr), .vp_wr(vp_wr), .x_in(x_in), .vp_wdata(vp_wdata),
    .mode(mode), .operand(operand), .idx_in(idx_in), .sp_in(sp_in),
    .b_in(b_in), .ptr_in(ptr_in), .vec_sel(vec_sel), .vec_byte(vec_byte),
    .xfer_sel(xfer_sel), .ea(ea), .ptr_wb(ptr_wb), .ptr_wb_en(ptr_wb_en),
    .sp_next(sp_next), .vec_addr(vec_addr), .x_out(x_out),
    .flag_n(flag_n), .flag_z(flag_z)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input bit d, input bit s, input bit v, input bit sr,
                      input logic [7:0] x, input logic [15:0] w);
    @(negedge clk);
    dp_wr = d; spg_wr = s; vp_wr = v; soft_rst = sr; x_in = x; vp_wdata = w;
    @(negedge clk);
    dp_wr = 0; spg_wr = 0; vp_wr = 0; soft_rst = 0;
  endtask

  function automatic int vec_exp(int vp, int sel, int byt);
    int off = (sel == 0) ? 0 : (sel == 1) ? 2 : 4;
    return (vp + off + byt) % 65536;
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int dps[6];
    int idxs[5];
    int ptrs[7];
    int vps[5];
    dps  = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF};
    idxs = '{0, 1, 8'h80, 8'hFE, 8'hFF};
    ptrs = '{16'h0000, 16'h0001, 16'h00FF, 16'h7FFF, 16'hFFFF, 16'h1234, 16'hFF80};
    vps  = '{16'hFFFA, 16'h0000, 16'hFFFC, 16'hFFFE, 16'h1230};
    rst_n = 0; soft_rst = 0; dp_wr = 0; spg_wr = 0; vp_wr = 0;
    x_in = 0; vp_wdata = 0; mode = 0; operand = 0; idx_in = 0; sp_in = 0;
    b_in = 0; ptr_in = 0; vec_sel = 0; vec_byte = 0; xfer_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset values
    mode = 3'd0; operand = 8'h34; #1 check("R1 dp reset", ea, 16'h0034);
    mode = 3'd2; sp_in = 8'hFD;   #1 check("R1 stack page reset", ea, 16'h01FD);
    vec_sel = 2'd1; vec_byte = 0; #1 check("R1 vector base reset", vec_addr, 16'hFFFC);

    // R2 R3 R4 R10 zero-page sweeps over each direct page
    foreach (dps[i]) begin
      load(1, 0, 0, 0, dps[i][7:0], 16'h0);
      for (int op = 0; op < 256; op++) begin
        operand = op[7:0];
        mode = 3'd0; #1 check("R2 R10 direct", ea, dps[i] * 256 + op);
        check("R8 no wb direct", ptr_wb_en, 0);
        mode = 3'd7; #1 check("R4 ptr high loc", ea, dps[i] * 256 + (op + 1) % 256);
        foreach (idxs[k]) begin
          mode = 3'd1; idx_in = idxs[k][7:0];
          #1 check("R3 indexed wrap", ea, dps[i] * 256 + (op + idxs[k]) % 256);
        end
      end
    end

    // R5 R10 stack sweeps
    foreach (dps[i]) begin
      load(0, 1, 0, 0, dps[i][7:0], 16'h0);
      for (int s = 0; s < 256; s++) begin
        sp_in = s[7:0];
        mode = 3'd2; #1 check("R5 push ea", ea, dps[i] * 256 + s);
        check("R5 push sp_next", sp_next, (s + 255) % 256);
        mode = 3'd3; #1 check("R5 pull ea", ea, dps[i] * 256 + (s + 1) % 256);
        check("R5 pull sp_next", sp_next, (s + 1) % 256);
        mode = 3'd6; #1 check("R5 other sp_next", sp_next, s);
      end
    end

    // R6 R7 R8 pointer adjustment
    foreach (ptrs[i]) begin
      ptr_in = ptrs[i][15:0];
      for (int b = 0; b < 256; b++) begin
        b_in = b[7:0];
        mode = 3'd4; #1 check("R6 post ea", ea, ptrs[i]);
        check("R6 post wb", ptr_wb, (ptrs[i] + b) % 65536);
        check("R6 post wb_en", ptr_wb_en, 1);
        mode = 3'd5; #1 check("R7 pre ea", ea, (ptrs[i] - b + 65536) % 65536);
        check("R7 pre wb", ptr_wb, (ptrs[i] - b + 65536) % 65536);
        check("R7 pre wb_en", ptr_wb_en, 1);
        mode = 3'd6; #1 check("R8 plain ea", ea, ptrs[i]);
        check("R8 plain wb_en", ptr_wb_en, 0);
      end
    end

    // R9 R10 vectors
    foreach (vps[i]) begin
      load(0, 0, 1, 0, 8'h0, vps[i][15:0]);
      for (int s = 0; s < 4; s++)
        for (int y = 0; y < 2; y++) begin
          vec_sel = s[1:0]; vec_byte = y[0];
          #1 check("R9 R10 vector", vec_addr, vec_exp(vps[i], s, y));
        end
    end

    // R11 copy to X
    load(1, 1, 0, 0, 8'h80, 16'h0);
    xfer_sel = 0; #1 check("R11 dp x_out", x_out, 8'h80);
    check("R11 n set", flag_n, 1); check("R11 z clear", flag_z, 0);
    load(0, 1, 0, 0, 8'h00, 16'h0);
    xfer_sel = 1; #1 check("R11 spg x_out", x_out, 0);
    check("R11 z set", flag_z, 1); check("R11 n clear", flag_n, 0);
    load(1, 0, 0, 0, 8'h7F, 16'h0);
    xfer_sel = 0; #1 check("R11 n clear 7F", flag_n, 0);
    check("R11 z clear 7F", flag_z, 0);

    // R12 soft reset beats simultaneous loads
    load(1, 1, 1, 0, 8'h55, 16'h1234);
    load(1, 1, 1, 1, 8'h77, 16'h4321);
    mode = 3'd0; operand = 8'h10; #1 check("R12 dp reload", ea, 16'h0010);
    mode = 3'd2; sp_in = 8'h20;   #1 check("R12 spg reload", ea, 16'h0120);
    vec_sel = 2'd2; vec_byte = 1; #1 check("R12 vp reload", vec_addr, 16'hFFFF);
    xfer_sel = 1; #1 check("R12 spg via x_out", x_out, 8'h01);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule